// File: doc/BRIEF.md
# Gigabit Ethernet Idle Set Rewriter

This block sits on a Gigabit Ethernet transmit path, just ahead of the 8b/10b encoder. It takes one symbol per cycle: an 8-bit value, a flag that marks it as a control character, and a valid strobe. It looks for two-symbol ordered sets that open with the comma character K28.5 (0xBC with the control flag set). When the second symbol of such a set is an ordinary data character that does not belong to a configuration set, the block replaces it. The choice of replacement makes the idle set leave the encoder with negative running disparity.

The encoder sends its current running disparity back on `rd_pos`. The block samples that input in the cycle the K28.5 is accepted. If the disparity is positive at that point, the K28.5 ends negative, so the filler is the neutral D5.6 (0xC5) and the pair is an /I1/. If the disparity is negative, the K28.5 ends positive, so the filler is D16.2 (0x50), which ends negative, and the pair is an /I2/. The two configuration fillers, D21.5 (0xB5) and D2.2 (0x42), are never rewritten. All other traffic passes unchanged through one register stage.

Top module: `gbe_idle_converter`

## Requirements
- R1: Every input symbol appears at the output exactly one clock later. `out_valid` equals the `in_valid` of the previous cycle. A symbol that is not rewritten keeps its value and its control flag.
- R2: An accepted K28.5 (value 0xBC with `in_k`=1) is passed to the output unchanged, as 0xBC with `out_k`=1.
- R3: Suppose K28.5 was accepted while `rd_pos`=1. If the next valid symbol is a data character (`in_k`=0) other than 0xB5 or 0x42, it is output as D5.6: 0xC5 with `out_k`=0.
- R4: Suppose K28.5 was accepted while `rd_pos`=0. If the next valid symbol is a data character other than 0xB5 or 0x42, it is output as D16.2: 0x50 with `out_k`=0.
- R5: A data character 0xB5 (D21.5) or 0x42 (D2.2) that follows a K28.5 is passed through unchanged.
- R6: Only the first valid symbol after a K28.5 can be replaced. Later data symbols pass unchanged.
- R7: Cycles with `in_valid`=0 between a K28.5 and its second symbol do not break the pairing. The disparity captured with the K28.5 is the one used, whatever `rd_pos` does during the gap.
- R8: A control symbol that follows a K28.5 is never replaced. If that symbol is itself a K28.5, it opens a new set and captures `rd_pos` again.
- R9: While `rst` is high, `out_valid` is 0. A K28.5 presented during reset does not open a set, so the first data symbol after reset passes unchanged.
- R10: Control characters other than K28.5 (for example K28.0, 0x1C) do not open a set, and the data that follows them passes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol strobe |
| in_data | input | SYM_W | Input symbol value |
| in_k | input | 1 | Input symbol is a control character |
| rd_pos | input | 1 | Encoder running disparity, 1 = positive |
| out_valid | output | 1 | Output symbol strobe, one cycle after input |
| out_data | output | SYM_W | Output symbol value, possibly rewritten |
| out_k | output | 1 | Output control flag |

## Verification
The hardest case to reach from the ports is a gap: the pairing state and the captured disparity must survive several idle cycles while `rd_pos` toggles. The stimulus sends a K28.5 with one disparity, flips `rd_pos` during the invalid cycles, and then checks that the filler still follows the disparity sampled with the comma. A second hard case is two consecutive K28.5 characters under opposite disparities. This shows that the second comma restarts the set and takes a fresh sample, and it is exercised by changing `rd_pos` between the two commas.

// File: rtl/gbe_idle_pkg.sv
package gbe_idle_pkg;
  localparam logic [7:0] SYM_COMMA  = 8'hBC; // K28.5
  localparam logic [7:0] SYM_FILL1  = 8'hC5; // D5.6, neutral
  localparam logic [7:0] SYM_FILL2  = 8'h50; // D16.2, ends negative
  localparam logic [7:0] SYM_CFG_A  = 8'hB5; // D21.5
  localparam logic [7:0] SYM_CFG_B  = 8'h42; // D2.2

  typedef enum logic {TRK_OPEN, TRK_COMMA} trk_state_t;
endpackage

// File: rtl/gbe_set_tracker.sv
module gbe_set_tracker #(
  parameter int          SYM_W     = 8,
  parameter logic [SYM_W-1:0] COMMA_SYM = gbe_idle_pkg::SYM_COMMA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_k,
  input  logic             rd_pos,
  output logic             after_comma,
  output logic             rd_hold
);
  import gbe_idle_pkg::*;

  trk_state_t state_q;
  logic       is_comma;

  assign is_comma    = in_k && (in_data == COMMA_SYM);
  assign after_comma = (state_q == TRK_COMMA);

  // Advances only on valid symbols, so gaps keep the pairing.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_OPEN;
      rd_hold <= 1'b0;
    end else if (in_valid) begin
      if (is_comma) begin
        state_q <= TRK_COMMA;
        rd_hold <= rd_pos;
      end else begin
        state_q <= TRK_OPEN;
      end
    end
  end
endmodule

// File: rtl/gbe_cfg_match.sv
module gbe_cfg_match #(
  parameter int SYM_W   = 8,
  parameter int NUM_CFG = 2,
  parameter logic [NUM_CFG*SYM_W-1:0] CFG_LIST =
    {gbe_idle_pkg::SYM_CFG_B, gbe_idle_pkg::SYM_CFG_A}
) (
  input  logic [SYM_W-1:0] sym,
  output logic             hit
);
  logic [NUM_CFG-1:0] match;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cmp
    assign match[g] = (sym == CFG_LIST[g*SYM_W +: SYM_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/gbe_sym_reg.sv
module gbe_sym_reg #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [SYM_W-1:0] d_data,
  input  logic             d_k,
  output logic             q_valid,
  output logic [SYM_W-1:0] q_data,
  output logic             q_k
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_k     <= 1'b0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_data <= d_data;
        q_k    <= d_k;
      end
    end
  end
endmodule

// File: rtl/gbe_idle_converter.sv
module gbe_idle_converter #(
  parameter int SYM_W   = 8,
  parameter int NUM_CFG = 2,
  parameter logic [SYM_W-1:0] COMMA_SYM = gbe_idle_pkg::SYM_COMMA,
  parameter logic [SYM_W-1:0] FILL_POS  = gbe_idle_pkg::SYM_FILL1,
  parameter logic [SYM_W-1:0] FILL_NEG  = gbe_idle_pkg::SYM_FILL2,
  parameter logic [NUM_CFG*SYM_W-1:0] CFG_LIST =
    {gbe_idle_pkg::SYM_CFG_B, gbe_idle_pkg::SYM_CFG_A}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_k,
  input  logic             rd_pos,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_k
);
  logic             after_comma;
  logic             rd_hold;
  logic             cfg_hit;
  logic             swap;
  logic [SYM_W-1:0] next_data;

  gbe_set_tracker #(.SYM_W(SYM_W), .COMMA_SYM(COMMA_SYM)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_k        (in_k),
    .rd_pos      (rd_pos),
    .after_comma (after_comma),
    .rd_hold     (rd_hold)
  );

  gbe_cfg_match #(.SYM_W(SYM_W), .NUM_CFG(NUM_CFG), .CFG_LIST(CFG_LIST)) u_cfg (
    .sym (in_data),
    .hit (cfg_hit)
  );

  always_comb begin
    swap      = in_valid && after_comma && !in_k && !cfg_hit;
    next_data = in_data;
    if (swap) next_data = rd_hold ? FILL_POS : FILL_NEG;
  end

  gbe_sym_reg #(.SYM_W(SYM_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_data  (next_data),
    .d_k     (in_k),
    .q_valid (out_valid),
    .q_data  (out_data),
    .q_k     (out_k)
  );
endmodule

// File: rtl/gbe_idle_checker.sv
module gbe_idle_checker #(
  parameter int SYM_W   = 8,
  parameter int NUM_CFG = 2,
  parameter logic [SYM_W-1:0] COMMA_SYM = gbe_idle_pkg::SYM_COMMA,
  parameter logic [SYM_W-1:0] FILL_POS  = gbe_idle_pkg::SYM_FILL1,
  parameter logic [SYM_W-1:0] FILL_NEG  = gbe_idle_pkg::SYM_FILL2,
  parameter logic [NUM_CFG*SYM_W-1:0] CFG_LIST =
    {gbe_idle_pkg::SYM_CFG_B, gbe_idle_pkg::SYM_CFG_A}
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [SYM_W-1:0] in_data,
  input logic             in_k,
  input logic             rd_pos,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_data,
  input logic             out_k
);
  logic pend;
  logic pend_rd;
  logic in_cfg;
  logic in_comma;

  assign in_comma = in_valid && in_k && (in_data == COMMA_SYM);

  always_comb begin
    in_cfg = 1'b0;
    for (int i = 0; i < NUM_CFG; i++)
      if (in_data == CFG_LIST[i*SYM_W +: SYM_W]) in_cfg = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pend_rd <= 1'b0;
    end else if (in_valid) begin
      pend    <= in_comma;
      if (in_comma) pend_rd <= rd_pos;
    end
  end

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R2
  a_r2_comma_kept: assert property (@(posedge clk) disable iff (rst)
    in_comma |=> (out_k && out_data == COMMA_SYM));

  // R3, R7
  a_r3_idle_one: assert property (@(posedge clk) disable iff (rst)
    (pend && pend_rd && in_valid && !in_k && !in_cfg) |=>
      (out_data == FILL_POS && !out_k));

  // R4, R7
  a_r4_idle_two: assert property (@(posedge clk) disable iff (rst)
    (pend && !pend_rd && in_valid && !in_k && !in_cfg) |=>
      (out_data == FILL_NEG && !out_k));

  // R5
  a_r5_config_kept: assert property (@(posedge clk) disable iff (rst)
    (pend && in_valid && !in_k && in_cfg) |=>
      (out_data == $past(in_data) && !out_k));

  // R8
  a_r8_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
    (pend && in_valid && in_k) |=>
      (out_data == $past(in_data) && out_k));
endmodule

bind gbe_idle_converter gbe_idle_checker #(
  .SYM_W(SYM_W), .NUM_CFG(NUM_CFG), .COMMA_SYM(COMMA_SYM),
  .FILL_POS(FILL_POS), .FILL_NEG(FILL_NEG), .CFG_LIST(CFG_LIST)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_k(in_k), .rd_pos(rd_pos), .out_valid(out_valid),
  .out_data(out_data), .out_k(out_k)
);

// File: tb/gbe_idle_converter_tb.sv
module gbe_idle_converter_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_k = 1'b0;
  logic       rd_pos = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_k;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gbe_idle_converter u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_k(in_k), .rd_pos(rd_pos), .out_valid(out_valid),
    .out_data(out_data), .out_k(out_k)
  );

  // Drive one symbol, then sample the registered result after the edge.
  task automatic step(input bit v, input logic [7:0] d, input bit k,
                      input bit rd, input bit ev, input logic [7:0] ed,
                      input bit ek, input string tag);
    @(negedge clk);
    in_valid = v; in_data = d; in_k = k; rd_pos = rd;
    @(posedge clk);
    #1;
    n_chk++;
    if (out_valid !== ev || (ev && (out_data !== ed || out_k !== ek))) begin
      n_err++;
      $display("FAIL %s: got v=%0b d=%02h k=%0b, expected v=%0b d=%02h k=%0b",
               tag, out_valid, out_data, out_k, ev, ed, ek);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = 8'hBC; in_k = 1'b1;
    @(posedge clk); #1;
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R9: got out_valid=%0b, expected 0", out_valid);
    end
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    step(1, 8'h11, 0, 1, 1, 8'h11, 0, "R9 first data after reset");
  endtask

  task automatic t_pass();
    step(1, 8'h00, 0, 0, 1, 8'h00, 0, "R1 data 00");
    step(1, 8'hFF, 0, 1, 1, 8'hFF, 0, "R1 data FF");
    step(1, 8'h3C, 1, 0, 1, 8'h3C, 1, "R1 control 3C");
    step(1, 8'h1C, 1, 1, 1, 8'h1C, 1, "R10 K28.0");
    step(1, 8'h77, 0, 1, 1, 8'h77, 0, "R10 data after K28.0");
  endtask

  task automatic t_i1();
    step(1, 8'hBC, 1, 1, 1, 8'hBC, 1, "R2 comma rd+");
    step(1, 8'h4A, 0, 0, 1, 8'hC5, 0, "R3 filler D5.6");
    step(1, 8'h4A, 0, 0, 1, 8'h4A, 0, "R6 third symbol");
  endtask

  task automatic t_i2();
    step(1, 8'hBC, 1, 0, 1, 8'hBC, 1, "R2 comma rd-");
    step(1, 8'hC5, 0, 1, 1, 8'h50, 0, "R4 filler D16.2");
    step(1, 8'h33, 0, 1, 1, 8'h33, 0, "R6 after I2");
  endtask

  task automatic t_cfg();
    step(1, 8'hBC, 1, 1, 1, 8'hBC, 1, "R5 comma");
    step(1, 8'hB5, 0, 1, 1, 8'hB5, 0, "R5 D21.5 kept");
    step(1, 8'hBC, 1, 0, 1, 8'hBC, 1, "R5 comma");
    step(1, 8'h42, 0, 0, 1, 8'h42, 0, "R5 D2.2 kept");
  endtask

  task automatic t_gap();
    step(1, 8'hBC, 1, 1, 1, 8'hBC, 1, "R7 comma rd+");
    for (int i = 0; i < 3; i++)
      step(0, 8'h99, 0, 0, 0, 8'h00, 0, "R1 gap no valid");
    step(1, 8'h99, 0, 0, 1, 8'hC5, 0, "R7 filler after gap");
    step(1, 8'hBC, 1, 0, 1, 8'hBC, 1, "R7 comma rd-");
    step(0, 8'h00, 0, 1, 0, 8'h00, 0, "R1 gap no valid");
    step(1, 8'h01, 0, 1, 1, 8'h50, 0, "R7 filler after gap rd-");
  endtask

  task automatic t_kk();
    step(1, 8'hBC, 1, 0, 1, 8'hBC, 1, "R8 first comma rd-");
    step(1, 8'hBC, 1, 1, 1, 8'hBC, 1, "R8 second comma kept");
    step(1, 8'h12, 0, 0, 1, 8'hC5, 0, "R8 new set uses rd+");
    step(1, 8'hBC, 1, 1, 1, 8'hBC, 1, "R8 comma");
    step(1, 8'hF7, 1, 1, 1, 8'hF7, 1, "R8 control after comma");
    step(1, 8'h12, 0, 1, 1, 8'h12, 0, "R8 data after control");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_pass();
    t_i1();
    t_i2();
    t_cfg();
    t_gap();
    t_kk();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule